// File: doc/BRIEF.md
# Serial Port Baud Clock Generator

This block produces the timing enables for a serial port. A 12-bit divisor, split over a low byte and a high nibble, sets the rate of a prescaler. The prescaler is a down-counter that emits a one-cycle `baud_tick` every divisor+1 system clocks. In asynchronous operation that tick serves as the 16x oversampling enable for the receiver and transmitter. In synchronous master operation a small state machine toggles a serial clock on every tick. It also issues a shift strobe for transmit data and a sample strobe for receive data, one cycle ahead of the serial clock edge they belong to.

Software reaches the block through a byte-wide bus with a write strobe, a one-bit address, write data and combinational read data. Address 0 holds the divisor low byte. Address 1 is shared by the divisor high nibble and a control register, and bit 7 of each written byte picks the target. Writing the low byte loads the prescaler at once with the new full divisor. Writing the high nibble on its own waits for the next natural reload.

The serial clock state machine has three states. `ST_ASYNC` holds the serial clock low. `ST_LOW` and `ST_HIGH` are the two phases of the synchronous serial clock. The transitions are:
- `ST_ASYNC -> ST_LOW` when synchronous mode is enabled.
- `ST_LOW -> ST_HIGH` on a tick.
- `ST_HIGH -> ST_LOW` on a tick.
- `ST_LOW` or `ST_HIGH` `-> ST_ASYNC` when synchronous mode is cleared.

Top module: `baud_clkgen`

## Requirements
- R1: A write to address 0 stores `bus_wdata` as divisor bits 7:0. While `bus_addr` is 0, `bus_rdata` shows that byte in the same cycle, with no read latency.
- R2: A write to address 1 with bit 7 = 0 stores bits 3:0 as divisor bits 11:8 and leaves the control register unchanged. A write with bit 7 = 1 stores bit 1 as the synchronous-mode enable and bit 0 as the polarity, and leaves the divisor unchanged.
- R3: While `bus_addr` is 1, `bus_rdata` returns the divisor high nibble in bits 3:0 and zero in bits 7:4, including the select bit and the reserved bits 6:4, whatever was written there.
- R4: A write to address 0 loads the prescaler with the new 12-bit divisor D in the cycle of the write. `baud_tick` is then low for the next D+1 cycles and high in the cycle after. This holds even when the write coincides with the counter reaching zero, and then the tick that would have followed is dropped.
- R5: With no low-byte write, `baud_tick` is high for exactly one cycle in every D+1 cycles. For D = 0 it stays high continuously.
- R6: A high-nibble write does not disturb the running count. The period in progress finishes with the old divisor, and the following periods use the new one.
- R7: In synchronous mode `sclk` inverts in the cycle after each `baud_tick`. In asynchronous mode `sclk` is 0 from the second cycle after the control write that clears synchronous mode.
- R8: In synchronous mode, each tick raises exactly one strobe, in the cycle before the `sclk` edge it belongs to. With polarity 0, `shift_stb` comes before the rising edge and `sample_stb` before the falling edge. With polarity 1 the two are swapped.
- R9: In asynchronous mode `shift_stb` and `sample_stb` stay 0 whatever the polarity bit holds.
- R10: After reset the divisor, polarity, mode and counter are 0. Reads return 0, `sclk` and the strobes are 0, and `baud_tick` is high from the first cycle after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 1 | 0: divisor low byte, 1: high nibble / control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| baud_tick | output | 1 | One-cycle prescaler tick (16x enable in asynchronous mode) |
| sclk | output | 1 | Synchronous serial clock |
| shift_stb | output | 1 | Transmit data change strobe |
| sample_stb | output | 1 | Receive data sample strobe |

## Verification
Two events can land in the same cycle: a low-byte write and the prescaler reaching zero on its own. The bench provokes this by locking onto an observed tick and counting D cycles. It then issues the low-byte write in exactly the cycle where the counter holds zero. The write must win. The bench expects no tick in the following cycle and the first new tick after D'+1 further quiet cycles, where D' is the new divisor.

// File: rtl/baud_pkg.sv
package baud_pkg;
    // control register bit positions within a control write
    localparam int CTRL_POL_BIT  = 0;
    localparam int CTRL_SYNC_BIT = 1;

    typedef enum logic [1:0] {
        ST_ASYNC = 2'd0,
        ST_LOW   = 2'd1,
        ST_HIGH  = 2'd2
    } sclk_state_e;
endpackage

// File: rtl/baud_regs.sv
module baud_regs
    import baud_pkg::*;
#(
    parameter int BUS_W = 8,
    parameter int HI_W  = 4,
    localparam int DIV_W = BUS_W + HI_W,
    localparam int SEL_BIT = BUS_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             addr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output logic [DIV_W-1:0] div_o,
    output logic             reload_o,
    output logic [DIV_W-1:0] reload_val_o,
    output logic             sync_o,
    output logic             pol_o
);
    logic [BUS_W-1:0] lo_q;
    logic [HI_W-1:0]  hi_q;
    logic             sync_q;
    logic             pol_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q   <= '0;
            hi_q   <= '0;
            sync_q <= 1'b0;
            pol_q  <= 1'b0;
        end else if (we) begin
            if (!addr) begin
                lo_q <= wdata;
            end else if (wdata[SEL_BIT]) begin
                sync_q <= wdata[CTRL_SYNC_BIT];
                pol_q  <= wdata[CTRL_POL_BIT];
            end else begin
                hi_q <= wdata[HI_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = addr ? {{(BUS_W-HI_W){1'b0}}, hi_q} : lo_q;
    end

    assign div_o        = {hi_q, lo_q};
    assign reload_o     = we && !addr;
    assign reload_val_o = {hi_q, wdata};
    assign sync_o       = sync_q;
    assign pol_o        = pol_q;

    AST_CTRL_KEEPS_DIV: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr && wdata[SEL_BIT]) |=> $stable(div_o)); // R2
    AST_HI_KEEPS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr && !wdata[SEL_BIT]) |=> ($stable(sync_o) && $stable(pol_o))); // R2
endmodule

// File: rtl/baud_prescale.sv
module baud_prescale #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    input  logic             reload_i,
    input  logic [DIV_W-1:0] reload_val_i,
    output logic             tick_o
);
    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            tick_o <= 1'b0;
        end else if (reload_i) begin
            cnt_q  <= reload_val_i;
            tick_o <= 1'b0;
        end else if (cnt_q == '0) begin
            cnt_q  <= div_i;
            tick_o <= 1'b1;
        end else begin
            cnt_q  <= cnt_q - 1'b1;
            tick_o <= 1'b0;
        end
    end

    AST_RELOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        reload_i |=> !tick_o); // R4
    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && !reload_i && ($past(div_i) != '0)) |=> !tick_o); // R5
endmodule

// File: rtl/sclk_fsm.sv
module sclk_fsm
    import baud_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic sync_i,
    input  logic pol_i,
    output logic sclk_o,
    output logic shift_o,
    output logic sample_o
);
    sclk_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ASYNC: if (sync_i) state_d = ST_LOW;
            ST_LOW: begin
                if (!sync_i)     state_d = ST_ASYNC;
                else if (tick_i) state_d = ST_HIGH;
            end
            ST_HIGH: begin
                if (!sync_i)     state_d = ST_ASYNC;
                else if (tick_i) state_d = ST_LOW;
            end
            default: state_d = ST_ASYNC;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ASYNC;
        else        state_q <= state_d;
    end

    logic rise_evt, fall_evt;

    always_comb begin
        rise_evt = 1'b0;
        fall_evt = 1'b0;
        sclk_o   = 1'b0;
        unique case (state_q)
            ST_ASYNC: ;
            ST_LOW:   rise_evt = sync_i && tick_i;
            ST_HIGH: begin
                sclk_o   = 1'b1;
                fall_evt = sync_i && tick_i;
            end
            default: ;
        endcase
        shift_o  = pol_i ? fall_evt : rise_evt;
        sample_o = pol_i ? rise_evt : fall_evt;
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({shift_o, sample_o})); // R8
    AST_STROBE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_o || sample_o) |=> (sclk_o != $past(sclk_o))); // R7
    AST_SHIFT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_o && !pol_i) |=> sclk_o); // R8
    AST_ASYNC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_i |=> !sclk_o); // R7
endmodule

// File: rtl/baud_clkgen.sv
module baud_clkgen #(
    parameter int BUS_W = 8,
    parameter int HI_W  = 4,
    localparam int DIV_W = BUS_W + HI_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic             bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             baud_tick,
    output logic             sclk,
    output logic             shift_stb,
    output logic             sample_stb
);
    logic [DIV_W-1:0] div_w;
    logic [DIV_W-1:0] reload_val_w;
    logic             reload_w;
    logic             sync_w;
    logic             pol_w;

    baud_regs #(.BUS_W(BUS_W), .HI_W(HI_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .we           (bus_we),
        .addr         (bus_addr),
        .wdata        (bus_wdata),
        .rdata        (bus_rdata),
        .div_o        (div_w),
        .reload_o     (reload_w),
        .reload_val_o (reload_val_w),
        .sync_o       (sync_w),
        .pol_o        (pol_w)
    );

    baud_prescale #(.DIV_W(DIV_W)) u_presc (
        .clk          (clk),
        .rst_n        (rst_n),
        .div_i        (div_w),
        .reload_i     (reload_w),
        .reload_val_i (reload_val_w),
        .tick_o       (baud_tick)
    );

    sclk_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (baud_tick),
        .sync_i   (sync_w),
        .pol_i    (pol_w),
        .sclk_o   (sclk),
        .shift_o  (shift_stb),
        .sample_o (sample_stb)
    );

    AST_ASYNC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_w |-> (!shift_stb && !sample_stb)); // R9
endmodule

// File: tb/sim_baud_clkgen.sv
module sim_baud_clkgen;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    // {sync, pol, divisor[11:0]}
    localparam logic [13:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 12'h000},
        {1'b1, 1'b1, 12'h003},
        {1'b0, 1'b1, 12'h005},
        {1'b1, 1'b0, 12'h0A2},
        {1'b1, 1'b1, 12'h107},
        {1'b0, 1'b0, 12'h001}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       baud_tick, sclk, shift_stb, sample_stb;

    int checks = 0;
    int fails  = 0;

    baud_clkgen u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .baud_tick(baud_tick),
        .sclk(sclk), .shift_stb(shift_stb), .sample_stb(sample_stb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    // k = 1 in the current cycle; returns the index of the first tick cycle
    task automatic wait_tick(output int k, input int lim);
        k = 1;
        while (!baud_tick && k < lim) begin
            @(negedge clk);
            k++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int k;
        logic s0;
        // reset state, R10
        repeat (3) @(negedge clk);
        bus_addr = 1'b0; #1;
        chk("R10 rdata lo", bus_rdata, 0);
        bus_addr = 1'b1; #1;
        chk("R10 rdata hi", bus_rdata, 0);
        chk("R10 sclk", sclk, 0);
        chk("R10 strobes", shift_stb | sample_stb, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 tick first cycle", baud_tick, 1);
        @(negedge clk);
        chk("R5 tick held for D=0", baud_tick, 1);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [11:0] d;
            logic sy, po;
            {sy, po, d} = VEC[i];
            wr(1'b1, {6'b100000, sy, po});
            wr(1'b1, {4'h0, d[11:8]});
            bus_addr = 1'b1; #1;
            chk("R2/R3 hi nibble read", bus_rdata, int'(d[11:8]));
            wr(1'b0, d[7:0]);
            bus_addr = 1'b0; #1;
            chk("R1 lo byte read", bus_rdata, int'(d[7:0]));
            wait_tick(k, 400);
            chk("R4 first tick index", k, int'(d) + 2);
            s0 = sclk;
            if (sy) begin
                chk("R8 shift strobe", shift_stb, po ? int'(s0) : int'(!s0));
                chk("R8 sample strobe", sample_stb, po ? int'(!s0) : int'(s0));
            end else begin
                chk("R9 strobes quiet", shift_stb | sample_stb, 0);
            end
            @(negedge clk);
            chk("R7 sclk after tick", sclk, sy ? int'(!s0) : 0);
            wait_tick(k, 400);
            chk("R5 tick period", k, int'(d) + 1);
        end

        // reserved bits and select bit read as zero, R3
        wr(1'b1, 8'h7A);
        bus_addr = 1'b1; #1;
        chk("R3 reserved read zero", bus_rdata, 8'h0A);

        // high nibble alone does not reload, R6
        wr(1'b1, 8'h80);
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h09);
        wait_tick(k, 400);
        chk("R4 tick index D=9", k, 11);
        wr(1'b1, 8'h01);
        wait_tick(k, 400);
        chk("R6 old period kept", k, 10);
        @(negedge clk);
        wait_tick(k, 400);
        chk("R6 new period used", k, 266);

        // low write in the same cycle the counter hits zero, R4
        repeat (265) @(negedge clk);
        wr(1'b0, 8'h04);
        chk("R4 collision tick dropped", baud_tick, 0);
        wait_tick(k, 400);
        chk("R4 collision reload index", k, 262);

        // control write keeps the divisor, R2
        wr(1'b1, 8'h83);
        bus_addr = 1'b1; #1;
        chk("R2 ctrl keeps hi", bus_rdata, 8'h01);
        bus_addr = 1'b0; #1;
        chk("R2 ctrl keeps lo", bus_rdata, 8'h04);

        // async with polarity 1 stays quiet, R9
        wr(1'b1, 8'h00);
        wr(1'b0, 8'h02);
        wr(1'b1, 8'h81);
        @(negedge clk);
        begin
            int act = 0;
            int ticks = 0;
            for (int c = 0; c < 40; c++) begin
                act += int'(sclk | shift_stb | sample_stb);
                ticks += int'(baud_tick);
                @(negedge clk);
            end
            chk("R9 async outputs quiet", act, 0);
            chk("R5 ticks in 40 cycles D=2", (ticks >= 13 && ticks <= 14) ? 1 : 0, 1);
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule